// File: doc/BRIEF.md
# Key-sequenced watchdog timer

This block is a down-counting watchdog whose control register only acts on pairs of magic words. Software writes a run-arm word followed by a run word to start the timer. Writing the same pair while the timer runs reloads it to the full count, which is how software keeps the system alive. A halt pair stops the timer, but only in builds where the `STOP_OK` parameter is set. In builds without that capability the halt words are not keys at all, so the timer can only end by expiring. The counter drops by one on each cycle in which the `tick` input is high. The time to expiry is therefore `LOAD_VAL` divided by the tick rate.

When the counter reaches zero while enabled, the block raises one of two reset requests for a fixed number of clock cycles and stops counting until it is started again. The setup register chooses which request is used: an internal-bus reset or a core reset. A sticky cause bit records the expiry. That bit outlives the system reset the request provokes. Only the power-on reset, or software writing 1 to the bit, clears it. The register port is plain and synchronous, with combinational read data.

Top module: `keyseq_wdog`

## Requirements
- R1: A control write (addr 0) of 0x1E1E1E1E, with the next control write being 0xE1E1E1E1, loads the counter with `LOAD_VAL` and sets the enable flag. The load takes effect on the clock edge of the second write.
- R2: While enabled, the counter drops by one on each clock edge where `tick` is high. It holds when `tick` is low. Reading addr 0 returns the counter value.
- R3: Repeating the run pair while the timer is enabled reloads the counter to `LOAD_VAL` (keep-alive).
- R4: After an arm word, a control write of any other word cancels the armed state and leaves the counter and enable flag unchanged. A run word arriving after that has no effect. Writes to other addresses do not disturb an armed state.
- R5: With `STOP_OK`=1, a control write of 0x1F1F1F1F with the next control write being 0xF1F1F1F1 clears the enable flag. The counter then holds its value.
- R6: With `STOP_OK`=0, the halt words are treated like any other non-key word. The timer keeps counting and can only be stopped by expiry.
- R7: When the enable flag is set and the counter is 0, the next edge clears the enable flag. From that edge, the selected reset request is high for exactly `RST_PULSE` cycles (default 8), and the counter stays at 0.
- R8: Setup register (addr 1): bit 0 selects the reset action, where 1 means `ib_rst_req` and 0 means `core_rst_req`. Bit 0 is updated only by a write whose bit 31 is 1. A read returns the action in bit 0 and the enable flag in bit 1. The two requests are never high together.
- R9: Cause register (addr 2): bit 5 becomes 1 on expiry. It survives `rst_n`. It is cleared only by `por_n` or by a write with bit 5 set.
- R10: After reset, the counter, the enable flag, the action bit and the cause bit read 0, and both requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| rst_n | input | 1 | System reset, active low, keeps cause bit and pulse |
| tick | input | 1 | Count enable from the bus clock tick |
| we | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 setup, 2 cause |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` |
| ib_rst_req | output | 1 | Internal-bus reset request pulse |
| core_rst_req | output | 1 | Core reset request pulse |

## Verification
On every cycle, the checker enforces the following:
- The decrement rule.
- That a request pulse can only rise after an enabled counter has reached zero.
- That the enable flag rises with the full load value.
- That the two requests are mutually exclusive.
- That the cause bit cannot drop without a clear write.
- That a build without the halt capability loses the enable flag only through expiry.

Some behaviour needs the bench's scenarios instead. These are the exact pulse length, the cycle in which expiry happens, the key-sequence aborts, the survival of the cause bit across a system reset, and how the two builds differ under the same halt pair.

// File: rtl/kswd_pkg.sv
package kswd_pkg;
   localparam logic [1:0]  A_CTL   = 2'd0;
   localparam logic [1:0]  A_SETUP = 2'd1;
   localparam logic [1:0]  A_CAUSE = 2'd2;

   localparam logic [31:0] K_RUN_ARM  = 32'h1E1E_1E1E;
   localparam logic [31:0] K_RUN      = 32'hE1E1_E1E1;
   localparam logic [31:0] K_HALT_ARM = 32'h1F1F_1F1F;
   localparam logic [31:0] K_HALT     = 32'hF1F1_F1F1;

   localparam int SET_ACT_BIT = 0;
   localparam int SET_EN_BIT  = 1;
   localparam int SET_WE_BIT  = 31;
   localparam int CAUSE_BIT   = 5;

   typedef enum logic [1:0] {
      KS_IDLE       = 2'd0,
      KS_RUN_ARMED  = 2'd1,
      KS_HALT_ARMED = 2'd2
   } key_st_e;
endpackage

// File: rtl/kswd_keydec.sv
module kswd_keydec
   import kswd_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit STOP_OK = 1'b1
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              ctl_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              start_p,
   output logic              stop_p
);
   key_st_e st_q, st_d;
   logic    is_run_arm, is_run, halt_arm_hit;

   assign is_run_arm = (wdata == DATA_W'(K_RUN_ARM));
   assign is_run     = (wdata == DATA_W'(K_RUN));

   generate
      if (STOP_OK) begin : g_halt
         logic is_halt_arm, is_halt;
         assign is_halt_arm  = (wdata == DATA_W'(K_HALT_ARM));
         assign is_halt      = (wdata == DATA_W'(K_HALT));
         assign halt_arm_hit = is_halt_arm;
         assign stop_p       = ctl_wr && (st_q == KS_HALT_ARMED) && is_halt;
      end else begin : g_nohalt
         assign halt_arm_hit = 1'b0;
         assign stop_p       = 1'b0;
      end
   endgenerate

   assign start_p = ctl_wr && (st_q == KS_RUN_ARMED) && is_run;

   always_comb begin
      st_d = st_q;
      if (ctl_wr) begin
         if (is_run_arm)        st_d = KS_RUN_ARMED;
         else if (halt_arm_hit) st_d = KS_HALT_ARMED;
         else                   st_d = KS_IDLE;
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) st_q <= KS_IDLE;
      else         st_q <= st_d;
   end
endmodule

// File: rtl/kswd_counter.sv
module kswd_counter #(
   parameter int               CNT_W    = 32,
   parameter logic [CNT_W-1:0] LOAD_VAL = '1
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             start_p,
   input  logic             stop_p,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt_q,
   output logic             en_q,
   output logic             expire_p
);
   logic at_zero;

   assign at_zero  = (cnt_q == '0);
   assign expire_p = en_q && at_zero && !start_p;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt_q <= '0;
         en_q  <= 1'b0;
      end else if (start_p) begin
         cnt_q <= LOAD_VAL;
         en_q  <= 1'b1;
      end else if (stop_p || expire_p) begin
         en_q  <= 1'b0;
      end else if (en_q && tick) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/kswd_action.sv
module kswd_action #(
   parameter int RST_PULSE = 8
) (
   input  logic clk,
   input  logic por_n,
   input  logic expire_p,
   input  logic act_sel,
   input  logic cause_clr,
   output logic ib_rst_req,
   output logic core_rst_req,
   output logic cause_q
);
   localparam int PW = $clog2(RST_PULSE + 1);
   localparam logic [PW-1:0] PLEN = PW'(RST_PULSE);

   logic [PW-1:0] pcnt_q;
   logic          act_q;
   logic          busy;

   assign busy         = (pcnt_q != '0);
   assign ib_rst_req   = busy && act_q;
   assign core_rst_req = busy && !act_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         pcnt_q <= '0;
         act_q  <= 1'b0;
      end else if (expire_p) begin
         pcnt_q <= PLEN;
         act_q  <= act_sel;
      end else if (busy) begin
         pcnt_q <= pcnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)         cause_q <= 1'b0;
      else if (expire_p)  cause_q <= 1'b1;
      else if (cause_clr) cause_q <= 1'b0;
   end
endmodule

// File: rtl/keyseq_wdog.sv
module keyseq_wdog
   import kswd_pkg::*;
#(
   parameter int               DATA_W    = 32,
   parameter int               CNT_W     = 32,
   parameter logic [CNT_W-1:0] LOAD_VAL  = '1,
   parameter int               RST_PULSE = 8,
   parameter bit               STOP_OK   = 1'b1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              we,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              ib_rst_req,
   output logic              core_rst_req
);
   generate
      if (DATA_W < 32) begin : g_bad_dw
         $error("keyseq_wdog: DATA_W must hold the 32-bit keys");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cw
         $error("keyseq_wdog: CNT_W out of range");
      end
      if (RST_PULSE < 1) begin : g_bad_pl
         $error("keyseq_wdog: RST_PULSE must be at least 1");
      end
      if (LOAD_VAL == '0) begin : g_bad_lv
         $error("keyseq_wdog: LOAD_VAL must be nonzero");
      end
   endgenerate

   logic             arst_n;
   logic             ctl_wr, set_wr, cause_clr;
   logic             start_p, stop_p, expire_p;
   logic [CNT_W-1:0] cnt_q;
   logic             en_q, act_sel_q, cause_q;

   assign arst_n    = por_n & rst_n;
   assign ctl_wr    = we && (addr == A_CTL);
   assign set_wr    = we && (addr == A_SETUP) && wdata[SET_WE_BIT];
   assign cause_clr = we && (addr == A_CAUSE) && wdata[CAUSE_BIT];

   kswd_keydec #(.DATA_W(DATA_W), .STOP_OK(STOP_OK)) u_keys (
      .clk(clk), .arst_n(arst_n), .ctl_wr(ctl_wr), .wdata(wdata),
      .start_p(start_p), .stop_p(stop_p)
   );

   kswd_counter #(.CNT_W(CNT_W), .LOAD_VAL(LOAD_VAL)) u_cnt (
      .clk(clk), .arst_n(arst_n), .start_p(start_p), .stop_p(stop_p),
      .tick(tick), .cnt_q(cnt_q), .en_q(en_q), .expire_p(expire_p)
   );

   kswd_action #(.RST_PULSE(RST_PULSE)) u_act (
      .clk(clk), .por_n(por_n), .expire_p(expire_p), .act_sel(act_sel_q),
      .cause_clr(cause_clr), .ib_rst_req(ib_rst_req),
      .core_rst_req(core_rst_req), .cause_q(cause_q)
   );

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)     act_sel_q <= 1'b0;
      else if (set_wr) act_sel_q <= wdata[SET_ACT_BIT];
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_CTL:   rdata = DATA_W'(cnt_q);
         A_SETUP: begin
            rdata[SET_ACT_BIT] = act_sel_q;
            rdata[SET_EN_BIT]  = en_q;
         end
         A_CAUSE: rdata[CAUSE_BIT] = cause_q;
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/kswd_chk.sv
module kswd_chk #(
   parameter int               CNT_W    = 32,
   parameter logic [CNT_W-1:0] LOAD_VAL = '1,
   parameter bit               STOP_OK  = 1'b1
) (
   input logic             clk,
   input logic             por_n,
   input logic             rst_n,
   input logic             tick,
   input logic [CNT_W-1:0] cnt_q,
   input logic             en_q,
   input logic             start_p,
   input logic             stop_p,
   input logic             cause_clr,
   input logic             cause_q,
   input logic             ib_rst_req,
   input logic             core_rst_req
);
   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (en_q && tick && cnt_q != '0 && !start_p && !stop_p) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R1
   load_on_enable_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      $rose(en_q) |-> (cnt_q == LOAD_VAL));

   // R7
   pulse_after_zero_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      $rose(ib_rst_req || core_rst_req) |-> ($past(en_q) && $past(cnt_q) == '0));

   // R8
   one_request_chk: assert property (@(posedge clk) disable iff (!por_n)
      !(ib_rst_req && core_rst_req));

   // R9
   cause_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      (cause_q && !cause_clr) |=> cause_q);

   // R6
   no_halt_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (!STOP_OK && $fell(en_q)) |-> ($past(cnt_q) == '0));
endmodule

bind keyseq_wdog kswd_chk #(.CNT_W(CNT_W), .LOAD_VAL(LOAD_VAL), .STOP_OK(STOP_OK)) u_chk (
   .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick), .cnt_q(cnt_q),
   .en_q(en_q), .start_p(start_p), .stop_p(stop_p), .cause_clr(cause_clr),
   .cause_q(cause_q), .ib_rst_req(ib_rst_req), .core_rst_req(core_rst_req)
);

// File: tb/tb_keyseq_wdog.sv
module tb_keyseq_wdog;
   localparam int L = 64;
   localparam int P = 8;
   localparam logic [1:0] CTL = 2'd0, SETUP = 2'd1, CAUSE = 2'd2;

   typedef struct packed {
      logic [1:0]  a;
      logic [31:0] d;
      logic [31:0] cnt;
      logic        en;
      logic        en_ns;
   } vec_t;

   localparam vec_t VT [14] = '{
      '{CTL,   32'h1E1E1E1E, 32'd0, 1'b0, 1'b0},
      '{CTL,   32'hE1E1E1E1, L,     1'b1, 1'b1},
      '{CTL,   32'h1E1E1E1E, L,     1'b1, 1'b1},
      '{CTL,   32'h12345678, L,     1'b1, 1'b1},
      '{CTL,   32'hE1E1E1E1, L,     1'b1, 1'b1},
      '{CTL,   32'h1F1F1F1F, L,     1'b1, 1'b1},
      '{CTL,   32'hF1F1F1F1, L,     1'b0, 1'b1},
      '{CTL,   32'h1E1E1E1E, L,     1'b0, 1'b1},
      '{SETUP, 32'h00000000, L,     1'b0, 1'b1},
      '{CTL,   32'hE1E1E1E1, L,     1'b1, 1'b1},
      '{CTL,   32'h1F1F1F1F, L,     1'b1, 1'b1},
      '{CTL,   32'hE1E1E1E1, L,     1'b1, 1'b1},
      '{CTL,   32'h1E1E1E1E, L,     1'b1, 1'b1},
      '{CTL,   32'hF1F1F1F1, L,     1'b1, 1'b1}
   };

   logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata, rdata_ns;
   logic ib_rst_req, core_rst_req, ib_ns, core_ns;
   int nchk = 0, nerr = 0;

   always #4 clk = ~clk;

   keyseq_wdog #(.LOAD_VAL(32'(L)), .RST_PULSE(P), .STOP_OK(1'b1)) dut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick), .we(we), .addr(addr),
      .wdata(wdata), .rdata(rdata), .ib_rst_req(ib_rst_req), .core_rst_req(core_rst_req));

   keyseq_wdog #(.LOAD_VAL(32'(L)), .RST_PULSE(P), .STOP_OK(1'b0)) dut_ns (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick), .we(we), .addr(addr),
      .wdata(wdata), .rdata(rdata_ns), .ib_rst_req(ib_ns), .core_rst_req(core_ns));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); we = 1'b1; addr = a; wdata = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v, output logic [31:0] vn);
      addr = a; #1; v = rdata; vn = rdata_ns;
   endtask

   task automatic ticks(input int n);
      @(negedge clk); tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      nchk++; nerr++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      logic [31:0] v, vn;
      int n, h;
      logic other;
      repeat (3) @(negedge clk);
      por_n = 1'b1; rst_n = 1'b1;
      // R10 reset state
      rd(CTL, v, vn);   check("R10 counter", v, 0);
      rd(SETUP, v, vn); check("R10 setup", v, 0);
      rd(CAUSE, v, vn); check("R10 cause", v, 0);
      check("R10 requests", {30'd0, ib_rst_req, core_rst_req}, 0);

      // R1 R4 R5 R6 key sequences from the table
      foreach (VT[i]) begin
         wr(VT[i].a, VT[i].d);
         rd(CTL, v, vn);   check("R1/R4 counter", v, VT[i].cnt);
         rd(SETUP, v, vn);
         check("R1/R4/R5 enable", {31'd0, v[1]}, {31'd0, VT[i].en});
         check("R6 enable no-halt", {31'd0, vn[1]}, {31'd0, VT[i].en_ns});
      end

      // R2 counting on tick
      ticks(10);
      rd(CTL, v, vn); check("R2 decrement", v, L - 10);
      // R3 keep-alive
      wr(CTL, 32'h1E1E1E1E); wr(CTL, 32'hE1E1E1E1);
      rd(CTL, v, vn); check("R3 reload", v, L);
      // R4 abort leaves counter
      ticks(5);
      wr(CTL, 32'h1E1E1E1E); wr(CTL, 32'h00000000); wr(CTL, 32'hE1E1E1E1);
      rd(CTL, v, vn); check("R4 aborted no reload", v, L - 5);
      // R5 / R6 halt pair
      wr(CTL, 32'h1F1F1F1F); wr(CTL, 32'hF1F1F1F1);
      ticks(3);
      rd(CTL, v, vn);
      check("R5 halted counter held", v, L - 5);
      check("R6 no-halt keeps counting", vn, L - 8);

      // R8 setup write with qualifier
      wr(SETUP, 32'h80000001);
      rd(SETUP, v, vn);
      check("R8 setup readback", v, 32'h1);
      check("R8 setup readback running", vn, 32'h3);

      // R7 expiry with internal-bus action
      wr(CTL, 32'h1E1E1E1E); wr(CTL, 32'hE1E1E1E1);
      tick = 1'b1;
      n = 0; other = 1'b0;
      do begin @(negedge clk); n++; other |= core_rst_req; end
      while (!ib_rst_req && n < 200);
      check("R7 expiry cycle", n, L + 1);
      check("R7 both builds expire", {31'd0, ib_ns}, 1);
      h = 0;
      while (ib_rst_req && h < 50) begin other |= core_rst_req; h++; @(negedge clk); end
      check("R7 pulse length", h, P);
      check("R8 core request idle", {31'd0, other}, 0);
      rd(CAUSE, v, vn); check("R9 cause set", v, 32'h20);
      rd(SETUP, v, vn); check("R7 enable cleared", v, 32'h1);
      rd(CTL, v, vn);   check("R7 counter stays zero", v, 0);
      tick = 1'b0;

      // R9 survives system reset
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      rd(CAUSE, v, vn); check("R9 survives rst_n", v, 32'h20);
      rd(SETUP, v, vn); check("R10 setup after rst_n", v, 0);
      wr(CAUSE, 32'h00000000);
      rd(CAUSE, v, vn); check("R9 zero write keeps", v, 32'h20);
      wr(CAUSE, 32'h00000020);
      rd(CAUSE, v, vn); check("R9 clear by write", v, 0);

      // R8 write without qualifier ignored
      wr(SETUP, 32'h00000001);
      rd(SETUP, v, vn); check("R8 unqualified ignored", v, 0);

      // R8 core action
      wr(CTL, 32'h1E1E1E1E); wr(CTL, 32'hE1E1E1E1);
      tick = 1'b1;
      n = 0; other = 1'b0;
      do begin @(negedge clk); n++; other |= ib_rst_req; end
      while (!core_rst_req && n < 200);
      check("R8 core expiry cycle", n, L + 1);
      h = 0;
      while (core_rst_req && h < 50) begin other |= ib_rst_req; h++; @(negedge clk); end
      check("R8 core pulse length", h, P);
      check("R8 ib request idle", {31'd0, other}, 0);
      tick = 1'b0;
      rd(CAUSE, v, vn); check("R9 cause set again", v, 32'h20);

      // R9 power-on reset clears cause
      @(negedge clk); por_n = 1'b0;
      @(negedge clk); por_n = 1'b1;
      rd(CAUSE, v, vn); check("R9 cleared by por_n", v, 0);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule